// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the synchronous control core of a single-port burst memory that has one shared data bus. On each rising clock edge it samples the address, the three chip selects, two address strobes, the advance input and the write controls. From these it classifies the cycle as one of the following: deselect, start of a read, start of a write, continuation of a burst, suspension of a burst, or idle. The classification drives per-lane write enables into an internal array of two 9-bit lanes. Read data leaves the block through an output register with one cycle of latency. A bus-drive enable tells the surrounding pad logic when to turn the shared data lines around.

Two address strobes load a new external address. When both are asserted, the processor strobe has priority. A processor-strobe access always opens as a read and can write only on later cycles. A controller-strobe access writes in its own cycle. Without a strobe, the low two address bits come from a wrapping burst sequencer, which follows either a linear order or an exclusive-or (interleaved) order. A static mode input selects the order.

Top module: `pbs_sram_ctl`

## Requirements
- R1: When the processor strobe and the controller strobe are both low and `sel1_n_i` is low, the cycle is treated as a processor-strobe read start, and no lane is written even if the write controls are active.
- R2: With `sel1_n_i` high, the processor strobe has no effect. If the controller strobe is also high, the cycle behaves as a no-strobe cycle: it continues or suspends the burst without sampling the chip selects. If the controller strobe is low, the cycle is a deselect.
- R3: A strobe cycle selects the device only when `sel1_n_i`=0, `sel2_i`=1 and `sel3_n_i`=0. Any other combination on a strobe cycle deselects the device, and `dout_en_o` is 0 from that clock edge on.
- R4: A processor-strobe load ignores the write controls and the advance input in its own cycle. A write on the following cycle lands at the loaded address, using the write controls sampled in that following cycle.
- R5: A controller-strobe load, taken with the processor strobe high and with any write control active, writes `din_i` at `addr_i` in that same cycle.
- R6: `gw_n_i`=0 writes both lanes. Otherwise, lane k (lane 0 = `din_i[8:0]`, lane 1 = `din_i[17:9]`) is written only when `bwe_n_i`=0 and `lane_n_i[k]`=0. A lane that is not written keeps its contents.
- R7: The word at the address registered at edge k appears on `dout_o` after edge k+1. `dout_en_o` follows `oe_n_i` combinationally within the cycle.
- R8: After reset, and in the first cycle after the device goes from deselected to selected, `dout_en_o` is 0 whatever the value of `oe_n_i`.
- R9: From the edge of any write cycle, `dout_en_o` is 0. It stays 0 through later no-strobe cycles until a strobe starts a new read.
- R10: In a no-strobe cycle while selected, `adv_n_i`=0 moves to the next burst address and `adv_n_i`=1 holds the current one. After four advances the burst is back at its first address.
- R11: With `burst_lin_i`=1, the low two bits step as (start+n) mod 4. With `burst_lin_i`=0, they step as start XOR n, for n = 0,1,2,3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address |
| sel1_n_i | input | 1 | Primary chip select, active low; also gates the processor strobe |
| sel2_i | input | 1 | Expansion chip select, active high |
| sel3_n_i | input | 1 | Expansion chip select, active low |
| strb_proc_n_i | input | 1 | Processor address strobe, active low |
| strb_ctl_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Write of all lanes, active low |
| bwe_n_i | input | 1 | Lane write qualifier, active low |
| lane_n_i | input | LANES | Per-lane write selects, active low |
| oe_n_i | input | 1 | Output enable, active low, not registered |
| burst_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved; static |
| din_i | input | LANES*LANE_W | Write data from the shared bus |
| dout_o | output | LANES*LANE_W | Registered read data |
| dout_en_o | output | 1 | Drive enable for the shared data bus |

## Verification
The assertions assume that every input holds a defined level from the first clock edge. They also assume that `burst_lin_i` does not change inside a burst: the suspend check watches only the sequencer state, and the order is read live. The bench holds the reset from time zero and changes inputs only on the falling edge. It returns every control to an inactive, selected level between scenarios, and it changes the burst order only across a fresh strobe load. Every word the bench reads back is written first, so no check ever compares against uninitialised array contents.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [2:0] {
    CY_IDLE  = 3'd0,
    CY_DESEL = 3'd1,
    CY_LD_RD = 3'd2,
    CY_LD_WR = 3'd3,
    CY_NX_RD = 3'd4,
    CY_NX_WR = 3'd5
  } cyc_e;

  // low two address bits for burst step n from a start offset
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] step,
                                          input logic       lin);
    return lin ? 2'(base + step) : (base ^ step);
  endfunction

endpackage

// File: rtl/pbs_cycle_dec.sv
module pbs_cycle_dec
  import pbs_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             active_i,
  input  logic             proc_n_i,
  input  logic             ctl_n_i,
  input  logic             sel1_n_i,
  input  logic             sel2_i,
  input  logic             sel3_n_i,
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] lane_n_i,
  output cyc_e             cyc_o,
  output logic [LANES-1:0] lane_we_o
);

  logic             proc_hit;
  logic             load;
  logic             chip_on;
  logic [LANES-1:0] mask;
  cyc_e             cyc;

  always_comb begin
    // processor strobe counts only while the primary select is low
    proc_hit = !proc_n_i && !sel1_n_i;
    load     = proc_hit || !ctl_n_i;
    chip_on  = !sel1_n_i && sel2_i && !sel3_n_i;
    if (!gw_n_i)       mask = '1;
    else if (!bwe_n_i) mask = ~lane_n_i;
    else               mask = '0;

    if (load) begin
      if (!chip_on)                 cyc = CY_DESEL;
      else if (!proc_hit && |mask)  cyc = CY_LD_WR;
      else                          cyc = CY_LD_RD;
    end else if (active_i) begin
      cyc = (|mask) ? CY_NX_WR : CY_NX_RD;
    end else begin
      cyc = CY_IDLE;
    end

    cyc_o     = cyc;
    lane_we_o = (cyc == CY_LD_WR || cyc == CY_NX_WR) ? mask : '0;
  end

endmodule

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] ext_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      base_q;
  logic [1:0]      step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      base_q <= '0;
      step_q <= '0;
    end else if (load_i) begin
      hi_q   <= ext_i[ADDR_W-1:2];
      base_q <= ext_i[1:0];
      step_q <= '0;
    end else if (adv_i) begin
      step_q <= 2'(step_q + 2'd1);
    end
  end

  assign addr_o = {hi_q, burst_lo(base_q, step_q, lin_i)};

  // R10: with no load and no advance the burst position is held
  a_r10_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_i) |=> ($stable(step_q) && $stable(hi_q) && $stable(base_q)));

endmodule

// File: rtl/pbs_lane_array.sv
module pbs_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    // simple dual-port, registered read: maps onto block RAM
    always_ff @(posedge clk) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
      rd_q <= mem[raddr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/pbs_sram_ctl.sv
module pbs_sram_ctl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    sel1_n_i,
  input  logic                    sel2_i,
  input  logic                    sel3_n_i,
  input  logic                    strb_proc_n_i,
  input  logic                    strb_ctl_n_i,
  input  logic                    adv_n_i,
  input  logic                    gw_n_i,
  input  logic                    bwe_n_i,
  input  logic [LANES-1:0]        lane_n_i,
  input  logic                    oe_n_i,
  input  logic                    burst_lin_i,
  input  logic [LANES*LANE_W-1:0] din_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    dout_en_o
);

  localparam int DATA_W = LANES * LANE_W;

  cyc_e              cyc;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] rd_word;
  logic              seq_load;
  logic              seq_adv;
  logic              active_q;
  logic              rdmode_q;
  logic              oval_q;

  pbs_cycle_dec #(.LANES(LANES)) u_dec (
    .active_i  (active_q),
    .proc_n_i  (strb_proc_n_i),
    .ctl_n_i   (strb_ctl_n_i),
    .sel1_n_i  (sel1_n_i),
    .sel2_i    (sel2_i),
    .sel3_n_i  (sel3_n_i),
    .gw_n_i    (gw_n_i),
    .bwe_n_i   (bwe_n_i),
    .lane_n_i  (lane_n_i),
    .cyc_o     (cyc),
    .lane_we_o (lane_we)
  );

  assign seq_load = (cyc == CY_LD_RD) || (cyc == CY_LD_WR);
  assign seq_adv  = ((cyc == CY_NX_RD) || (cyc == CY_NX_WR)) && !adv_n_i;

  pbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .load_i (seq_load),
    .adv_i  (seq_adv),
    .lin_i  (burst_lin_i),
    .ext_i  (addr_i),
    .addr_o (cur_addr)
  );

  // controller-strobe writes land on the external address, others on the burst address
  assign wr_addr = (cyc == CY_LD_WR) ? addr_i : cur_addr;

  pbs_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk     (clk),
    .we_i    (lane_we),
    .waddr_i (wr_addr),
    .wdata_i (din_i),
    .raddr_i (cur_addr),
    .rdata_o (rd_word)
  );

  // active: selected; rdmode: the registered address belongs to a read;
  // oval: output register holds a word that may be driven
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rdmode_q <= 1'b0;
      oval_q   <= 1'b0;
    end else begin
      case (cyc)
        CY_DESEL: begin
          active_q <= 1'b0;
          rdmode_q <= 1'b0;
          oval_q   <= 1'b0;
        end
        CY_LD_RD: begin
          oval_q   <= active_q && rdmode_q;
          active_q <= 1'b1;
          rdmode_q <= 1'b1;
        end
        CY_LD_WR: begin
          oval_q   <= 1'b0;
          active_q <= 1'b1;
          rdmode_q <= 1'b0;
        end
        CY_NX_RD: oval_q <= rdmode_q;
        CY_NX_WR: begin
          oval_q   <= 1'b0;
          rdmode_q <= 1'b0;
        end
        default:  oval_q <= 1'b0;
      endcase
    end
  end

  assign dout_o    = rd_word;
  assign dout_en_o = oval_q && !oe_n_i;

  // R1: an honoured processor strobe never writes in its own cycle
  a_r1_proc_no_write: assert property (@(posedge clk) disable iff (rst)
    (!strb_proc_n_i && !sel1_n_i) |-> (lane_we == '0));

  // R3: a strobe with a failing select combination leaves the bus undriven
  a_r3_desel_hiz: assert property (@(posedge clk) disable iff (rst)
    (((!strb_proc_n_i && !sel1_n_i) || !strb_ctl_n_i) &&
     !(!sel1_n_i && sel2_i && !sel3_n_i)) |=> !dout_en_o);

  // R5: controller strobe with the all-lane write writes both lanes at once
  a_r5_ctl_write_now: assert property (@(posedge clk) disable iff (rst)
    (strb_proc_n_i && !strb_ctl_n_i && !sel1_n_i && sel2_i && !sel3_n_i && !gw_n_i)
      |-> (lane_we == '1));

  // R9: a write cycle leaves the bus undriven after its edge
  a_r9_write_hiz: assert property (@(posedge clk) disable iff (rst)
    (lane_we != '0) |=> !dout_en_o);

  // R8: nothing is driven right after reset
  a_r8_reset_hiz: assert property (@(posedge clk)
    rst |=> !dout_en_o);

endmodule

// File: tb/tb_pbs_sram_ctl.sv
module tb_pbs_sram_ctl;

  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          s1_n = 1'b0, s2 = 1'b1, s3_n = 1'b0;
  logic          proc_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [1:0]    lane_n = 2'b11;
  logic          oe_n = 1'b1;
  logic          lin = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  always #4 clk = ~clk;

  pbs_sram_ctl dut (
    .clk(clk), .rst(rst), .addr_i(addr), .sel1_n_i(s1_n), .sel2_i(s2),
    .sel3_n_i(s3_n), .strb_proc_n_i(proc_n), .strb_ctl_n_i(ctl_n),
    .adv_n_i(adv_n), .gw_n_i(gw_n), .bwe_n_i(bwe_n), .lane_n_i(lane_n),
    .oe_n_i(oe_n), .burst_lin_i(lin), .din_i(din), .dout_o(dout),
    .dout_en_o(dout_en)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference model
  logic [DW-1:0] mm [64];
  bit            m_act, m_rdm, m_ov;
  logic [DW-1:0] m_od;
  int            m_hi, m_base, m_step;

  function automatic logic [DW-1:0] dat(input int a);
    return DW'((a * 1237 + 91) ^ 'h2B4C7);
  endfunction

  function automatic logic [DW-1:0] mrg(input logic [DW-1:0] old,
                                        input logic [DW-1:0] nw,
                                        input logic [1:0] msk);
    logic [DW-1:0] r;
    r = old;
    if (msk[0]) r[8:0]  = nw[8:0];
    if (msk[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  function automatic int m_cur();
    int lo;
    lo = lin ? ((m_base + m_step) % 4) : (m_base ^ m_step);
    return m_hi * 4 + lo;
  endfunction

  task automatic model_step();
    bit ph, ld, on;
    bit [1:0] msk;
    int cur;
    logic [DW-1:0] old;
    ph = !proc_n && !s1_n;
    ld = ph || !ctl_n;
    on = !s1_n && s2 && !s3_n;
    if (!gw_n) msk = 2'b11;
    else if (!bwe_n) msk = ~lane_n;
    else msk = 2'b00;
    cur = m_cur();
    old = mm[cur];
    if (ld) begin
      if (!on) begin
        m_act = 0; m_rdm = 0; m_ov = 0;
      end else begin
        if (!ph && msk != 0) begin
          mm[int'(addr)] = mrg(mm[int'(addr)], din, msk);
          m_ov = 0; m_rdm = 0;
        end else begin
          m_ov = m_act && m_rdm; m_od = old; m_rdm = 1;
        end
        m_act = 1;
        m_hi = int'(addr) / 4; m_base = int'(addr) % 4; m_step = 0;
      end
    end else if (m_act) begin
      if (msk != 0) begin
        mm[cur] = mrg(old, din, msk);
        m_ov = 0; m_rdm = 0;
      end else begin
        m_ov = m_rdm; m_od = old;
      end
      if (!adv_n) m_step = (m_step + 1) % 4;
    end else begin
      m_ov = 0;
    end
  endtask

  task automatic compare(input string req);
    bit exp_en;
    exp_en = m_ov && !oe_n;
    checks++;
    if (dout_en !== exp_en) begin
      errors++;
      $display("FAIL %s: dout_en=%b expected %b", req, dout_en, exp_en);
    end
    if (exp_en) begin
      checks++;
      if (dout !== m_od) begin
        errors++;
        $display("FAIL %s: dout=%h expected %h", req, dout, m_od);
      end
    end
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(req);
  endtask

  task automatic expect_word(input string req, input logic [DW-1:0] v);
    checks++;
    if (dout_en !== 1'b1 || dout !== v) begin
      errors++;
      $display("FAIL %s: en=%b dout=%h expected en=1 dout=%h", req, dout_en, dout, v);
    end
  endtask

  task automatic expect_hiz(input string req);
    checks++;
    if (dout_en !== 1'b0) begin
      errors++;
      $display("FAIL %s: dout_en=%b expected 0", req, dout_en);
    end
  endtask

  task automatic idle();
    proc_n = 1; ctl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; lane_n = 2'b11;
    s1_n = 0; s2 = 1; s3_n = 0;
  endtask

  task automatic proc_load(input int a);
    idle(); proc_n = 0; addr = AW'(a);
  endtask

  initial begin
    m_act = 0; m_rdm = 0; m_ov = 0; m_od = '0;
    m_hi = 0; m_base = 0; m_step = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_hiz("R8 reset");
    rst = 0;

    // R5: fill every word with controller-strobe writes
    oe_n = 1;
    for (int a = 0; a < 64; a++) begin
      idle(); ctl_n = 0; gw_n = 0; addr = AW'(a); din = dat(a);
      tick("R5 fill");
    end
    oe_n = 0;

    // R7/R8: single read, first cycle undriven, data one edge later
    proc_load(17); tick("R8 first");
    expect_hiz("R8 first cycle after select");
    idle(); tick("R7 latency");
    expect_word("R7 read 17 (R5 data)", dat(17));
    oe_n = 1; #1 expect_hiz("R7 oe high");
    oe_n = 0; #1 expect_word("R7 oe low", dat(17));

    // R10/R11 linear burst from 6: 6,7,4,5,6
    lin = 1;
    proc_load(6); tick("R11 load");
    idle(); adv_n = 0;
    tick("R11"); expect_word("R11 lin 6", dat(6));
    tick("R11"); expect_word("R11 lin 7", dat(7));
    tick("R11"); expect_word("R11 lin 4", dat(4));
    tick("R11"); expect_word("R11 lin 5", dat(5));
    tick("R10"); expect_word("R10 wrap 6", dat(6));
    adv_n = 1;
    tick("R10"); expect_word("R10 suspend 7", dat(7));
    tick("R10"); expect_word("R10 suspend again 7", dat(7));

    // R11 interleaved burst from 9: 9,8,11,10
    idle(); lin = 0; tick("R11 gap");
    proc_load(9); tick("R11 load");
    idle(); adv_n = 0;
    tick("R11"); expect_word("R11 il 9", dat(9));
    tick("R11"); expect_word("R11 il 8", dat(8));
    tick("R11"); expect_word("R11 il 11", dat(11));
    tick("R11"); expect_word("R11 il 10", dat(10));
    idle(); tick("R11 tail");
    lin = 1; tick("R11 gap");

    // R1: both strobes with writes active -> read, no write
    idle(); proc_n = 0; ctl_n = 0; gw_n = 0; addr = AW'(12); din = 18'h3FFFF;
    tick("R1");
    idle(); tick("R1");
    expect_word("R1 word 12 untouched", dat(12));

    // R2: processor strobe with sel1 high continues the burst
    idle(); proc_n = 0; s1_n = 1; adv_n = 0; tick("R2");
    idle(); tick("R2");
    expect_word("R2 burst advanced to 13", dat(13));
    idle(); proc_n = 0; s1_n = 1; ctl_n = 0; tick("R2");
    expect_hiz("R2 ctl strobe with sel1 high deselects");

    // R3: each failing select combination deselects at once
    for (int k = 0; k < 3; k++) begin
      proc_load(20); tick("R3 load");
      idle(); tick("R3 read");
      idle(); ctl_n = 0; addr = AW'(21);
      if (k == 0) s1_n = 1; else if (k == 1) s2 = 0; else s3_n = 1;
      tick("R3");
      expect_hiz("R3 deselect");
      idle(); tick("R3 idle");
      expect_hiz("R3 stays deselected");
    end

    // R4: processor load ignores writes/advance; next-cycle write at loaded address
    idle(); proc_n = 0; gw_n = 0; adv_n = 0; addr = AW'(30); din = 18'h00000;
    tick("R4 load");
    idle(); bwe_n = 0; lane_n = 2'b10; din = 18'h15555; tick("R4 write");
    expect_hiz("R9 write cycle undriven");
    proc_load(30); tick("R4");
    idle(); tick("R4");
    expect_word("R4 lane0 written at 30", {dat(30)[17:9], 9'h155});
    proc_load(31); tick("R4");
    idle(); tick("R4");
    expect_word("R4 word 31 untouched", dat(31));

    // R6: lane selects
    idle(); ctl_n = 0; bwe_n = 0; lane_n = 2'b01; addr = AW'(40); din = 18'h2AAAA;
    tick("R6 lane1");
    idle(); tick("R9 after write");
    expect_hiz("R9 stays undriven after write");
    idle(); ctl_n = 0; bwe_n = 1; lane_n = 2'b00; addr = AW'(41); din = 18'h11111;
    tick("R6 no qualifier");
    idle(); ctl_n = 0; gw_n = 0; bwe_n = 1; lane_n = 2'b11; addr = AW'(42); din = 18'h0F0F0;
    tick("R6 global");
    proc_load(40); tick("R6");
    idle(); tick("R6");
    expect_word("R6 lane1 only at 40", {9'h155, dat(40)[8:0]});
    proc_load(41); tick("R6");
    idle(); tick("R6");
    expect_word("R6 bwe high writes nothing at 41", dat(41));
    proc_load(42); tick("R6");
    idle(); tick("R6");
    expect_word("R6 global write at 42", 18'h0F0F0);

    // R9: write inside a read burst turns the bus off until a new strobe
    proc_load(44); tick("R9");
    idle(); tick("R9");
    expect_word("R9 read 44", dat(44));
    idle(); bwe_n = 0; lane_n = 2'b00; din = 18'h22222; tick("R9");
    expect_hiz("R9 write in burst");
    idle(); adv_n = 0; tick("R9");
    expect_hiz("R9 no strobe keeps bus off");
    proc_load(44); tick("R9");
    idle(); tick("R9");
    expect_word("R9 new strobe drives again", 18'h22222);

    idle(); tick("end");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule